// File: doc/BRIEF.md
# External Interrupt Controller with Input Noise Filter

This block collects four external interrupt pins and turns them into a single request to a CPU together with the vector address of the winning source. Each pin goes through a two-flop synchroniser. The highest-numbered pin then also passes through a digital noise-rejection filter. A pin must show a new level on two consecutive filter sample ticks before the filter passes that level on. The tick rate is the cycle clock divided by 1, 16 or 64.

Each source has its own trigger-mode select and enable, written through a small configuration port. Sources 0 and 1 can fire on a rising edge, a falling edge, a high level or a low level. Sources 2 and 3 can fire on a rising edge, a falling edge or either edge. An edge sets a pending flag, and an acknowledge clears the flag of the granted source. A level mode requests for as long as the level is present. A fixed priority picks one source at a time, and source 0 ranks highest.

Configuration port: `cfg_addr` 0 to 3 selects the source. `cfg_data[2:0]` is its mode code and `cfg_data[3]` its enable. `cfg_addr` 4 writes the filter divisor code in `cfg_data[1:0]`.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Sources 0 to 2 accept a pin pulse one cycle long. When a pin changes just after a clock edge, the resulting pending request shows on `irq` after the third following rising edge, and not earlier.
- R2: Mode codes for sources 0 and 1 are: 0 rising edge, 1 falling edge, 3 high level, 4 low level. An edge of the other polarity raises nothing.
- R3: Mode codes for sources 2 and 3 are: 0 rising edge, 1 falling edge, 2 either edge. In code 2, a pulse gives two separate requests.
- R4: A source whose mode code is unsupported never requests, whatever its pin does. The unsupported codes are 2, 5, 6 and 7 for sources 0 and 1, and 3 to 7 for sources 2 and 3.
- R5: While `irq` is high, `irq_vector` holds 8×n+3 for the granted source n (03h, 0Bh, 13h, 1Bh). While `irq` is low, it holds 00h.
- R6: When several sources request at once, the lowest-numbered one is granted. After each acknowledge, the next lowest is granted.
- R7: `irq_ack` clears the pending flag of the granted edge-mode source at that clock edge. A level-mode request stays high through an acknowledge while the level persists, and drops once the level goes away.
- R8: The source 3 filter samples on ticks at the clock divided by 1, 16 or 64 (divisor codes 0, 1, and 2 or 3). The filter moves its output only on a tick where both the current and previous tick sample agree on a new level. Pulses of at least 2, 32 or 128 cycles pass. Pulses shorter than one tick interval are rejected.
- R9: A disabled source records no pending flag. Writing the configuration of a source clears its pending flag.
- R10: After reset, `irq` is low, `irq_vector` is 00h, and all sources are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Active-low reset |
| irq_pins | input | 4 | Raw external interrupt pins, bit n is source n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0 to 3 source select, 4 filter divisor |
| cfg_data | input | 4 | Mode code [2:0] and enable [3], or divisor code [1:0] |
| irq | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 8 | Vector address of the granted source |
| irq_ack | input | 1 | Acknowledge of the granted request |

## Verification
The assertions assume that `irq_ack` is only meaningful while `irq` is high. They also assume that configuration writes use only the listed addresses, and that pins are low while reset is applied, so no false edge is seen at release. The stimulus drives pins and the configuration port only between clock edges and holds pins low through reset. A monitor acknowledges only a request it has just compared, and level-mode cases are handled by the driver with the monitor switched off.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int MODE_W = 3;
  localparam int VEC_W  = 8;
  localparam int DIV_W  = 6;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_BOTH = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_LOW  = 3'd4
  } trig_mode_e;

  // Sources below n_level are level capable, the rest are dual-edge capable.
  function automatic logic mode_supported(input int idx, input int n_level,
                                          input logic [MODE_W-1:0] m);
    if (idx < n_level)
      return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_HIGH) || (m == TRIG_LOW);
    else
      return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
  endfunction

  function automatic logic [VEC_W-1:0] vector_for(input int idx, input int base,
                                                  input int step);
    return VEC_W'(base + idx * step);
  endfunction

  // Counter bits that must be zero for a filter sample tick.
  function automatic logic [DIV_W-1:0] filter_mask(input logic [1:0] code);
    case (code)
      2'd0:    return DIV_W'(0);
      2'd1:    return DIV_W'(15);
      default: return DIV_W'(63);
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_noise_filter.sv
module irq_noise_filter
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_code,
  input  logic       din,
  output logic       dout
);
  logic [DIV_W-1:0] cnt_q;
  logic             samp_q;
  logic             filt_q;
  logic             tick;

  assign tick = ((cnt_q & filter_mask(div_code)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      samp_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (tick) begin
        samp_q <= din;
        if (samp_q == din && din != filt_q) filt_q <= din;
      end
    end
  end

  assign dout = filt_q;

  AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt_q)); // R8
  AST_FILT_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(samp_q) == filt_q)); // R8
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
  import ext_irq_pkg::*;
#(
  parameter int N       = 4,
  parameter int N_LEVEL = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           lvl,
  input  logic [N-1:0][MODE_W-1:0] mode,
  input  logic [N-1:0]           en,
  input  logic [N-1:0]           cfg_wr,
  input  logic [N-1:0]           ack_clr,
  output logic [N-1:0]           req
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise, fall, eff_en, evt, is_level, level_hit, pend_q;

    assign rise   = lvl[i] & ~prev_q[i];
    assign fall   = ~lvl[i] & prev_q[i];
    assign eff_en = en[i] & mode_supported(i, N_LEVEL, mode[i]);

    always_comb begin
      evt       = 1'b0;
      is_level  = 1'b0;
      level_hit = 1'b0;
      case (mode[i])
        TRIG_RISE: evt = rise;
        TRIG_FALL: evt = fall;
        TRIG_BOTH: evt = rise | fall;
        TRIG_HIGH: begin is_level = 1'b1; level_hit = lvl[i];  end
        TRIG_LOW:  begin is_level = 1'b1; level_hit = ~lvl[i]; end
        default:   evt = 1'b0;
      endcase
      evt       = evt & eff_en;
      level_hit = level_hit & eff_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (cfg_wr[i])  pend_q <= 1'b0;
      else if (evt)        pend_q <= 1'b1;
      else if (ack_clr[i]) pend_q <= 1'b0;
    end

    assign req[i] = is_level ? level_hit : pend_q;

    AST_NO_PEND_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_en |-> !pend_q); // R9
    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[i] && !evt) |=> !pend_q); // R7
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import ext_irq_pkg::*;
#(
  parameter int N        = 4,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic [N-1:0]     req,
  output logic             irq,
  output logic [VEC_W-1:0] vec,
  output logic [N-1:0]     grant
);
  always_comb begin
    grant = '0;
    vec   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vec      = vector_for(i, VEC_BASE, VEC_STEP);
      end
    end
  end

  assign irq = |req;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int N_LEVEL     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_pins,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [3:0]       cfg_data,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ack
);
  localparam int FILT_IDX = N_IRQ - 1;
  localparam int DIV_ADDR = N_IRQ;

  logic [N_IRQ-1:0][MODE_W-1:0] mode_q;
  logic [N_IRQ-1:0]             en_q;
  logic [1:0]                   div_q;
  logic [N_IRQ-1:0]             cfg_wr;
  logic [N_IRQ-1:0]             sync_lvl;
  logic [N_IRQ-1:0]             lvl;
  logic                         filt_lvl;
  logic [N_IRQ-1:0]             req;
  logic [N_IRQ-1:0]             grant;
  logic [N_IRQ-1:0]             ack_clr;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_wr
    assign cfg_wr[i] = cfg_we && (cfg_addr == 3'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      div_q  <= '0;
    end else begin
      for (int i = 0; i < N_IRQ; i++) begin
        if (cfg_wr[i]) begin
          mode_q[i] <= cfg_data[MODE_W-1:0];
          en_q[i]   <= cfg_data[3];
        end
      end
      if (cfg_we && cfg_addr == 3'(DIV_ADDR)) div_q <= cfg_data[1:0];
    end
  end

  irq_sync #(.W(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_pins), .q(sync_lvl));

  irq_noise_filter u_filt (
    .clk(clk), .rst_n(rst_n), .div_code(div_q),
    .din(sync_lvl[FILT_IDX]), .dout(filt_lvl));

  always_comb begin
    lvl           = sync_lvl;
    lvl[FILT_IDX] = filt_lvl;
  end

  irq_trigger #(.N(N_IRQ), .N_LEVEL(N_LEVEL)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode(mode_q), .en(en_q),
    .cfg_wr(cfg_wr), .ack_clr(ack_clr), .req(req));

  irq_arbiter #(.N(N_IRQ), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .req(req), .irq(irq), .vec(irq_vector), .grant(grant));

  assign ack_clr = grant & {N_IRQ{irq_ack}};

  AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_vector == '0)); // R5
  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vector[2:0] == 3'(VEC_BASE) && irq_vector < VEC_W'(VEC_BASE + N_IRQ * VEC_STEP))); // R5
  AST_TOP_SOURCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> (grant[0] && irq_vector == VEC_W'(VEC_BASE))); // R6
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $onehot(grant)); // R6
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [3:0] cfg_data = '0;
  logic       irq;
  logic [7:0] irq_vector;
  logic       ack_drv = 1'b0;
  logic       ack_mon = 1'b0;
  logic       mon_on = 1'b0;
  logic       done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R10";
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pins(pins), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .irq(irq),
    .irq_vector(irq_vector), .irq_ack(ack_drv | ack_mon));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int idx, input int w);
    @(negedge clk);
    pins[idx] = 1'b1;
    repeat (w) @(negedge clk);
    pins[idx] = 1'b0;
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic drain(input int n, input string tag);
    cyc(n);
    chk(exp_q.size() == 0, tag, "expected vectors never seen", exp_q.size(), 0);
    chk(irq == 1'b0, tag, "irq after drain", int'(irq), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic ack_once();
    @(negedge clk);
    ack_drv = 1'b1;
    @(negedge clk);
    ack_drv = 1'b0;
  endtask

  // Monitor: compare each request seen with the scoreboard, then acknowledge it.
  always @(negedge clk) begin
    if (mon_on && irq) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected request, vector", int'(irq_vector), 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        chk(irq_vector == e, t, "vector", int'(irq_vector), int'(e));
      end
      ack_mon <= 1'b1;
    end else begin
      ack_mon <= 1'b0;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(irq == 1'b0, "R10", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(irq == 1'b0, "R10", "irq after reset", int'(irq), 0);
    chk(irq_vector == 8'h00, "R10", "vector after reset", int'(irq_vector), 0);
    pins = 4'hF;
    cyc(10);
    chk(irq == 1'b0, "R10", "irq with all disabled", int'(irq), 0);
    pins = 4'h0;
    cyc(10);

    // R1: exact latency for a one-cycle pulse on source 0
    wr(3'd4, 4'h0);
    wr(3'd0, 4'h8);
    @(negedge clk) pins[0] = 1'b1;
    @(negedge clk) pins[0] = 1'b0;
    chk(irq == 1'b0, "R1", "irq one edge after pin", int'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b0, "R1", "irq two edges after pin", int'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R1", "irq three edges after pin", int'(irq), 1);
    chk(irq_vector == 8'h03, "R5", "vector source 0", int'(irq_vector), 8'h03);
    ack_once();
    chk(irq == 1'b0, "R7", "irq after ack of edge request", int'(irq), 0);

    // R2: falling edge only on source 0, rising edge on source 1
    mon_on <= 1'b1;
    cur_tag = "R2";
    wr(3'd0, 4'h9);
    @(negedge clk) pins[0] = 1'b1;
    cyc(10);
    push(8'h03, "R2");
    pins[0] = 1'b0;
    drain(10, "R2");
    wr(3'd0, 4'h0);
    wr(3'd1, 4'h8);
    push(8'h0B, "R1");
    pulse(1, 1);
    drain(10, "R1");

    // R2/R7: level modes on sources 1 and 0, driven directly
    mon_on <= 1'b0;
    wr(3'd1, 4'hC);
    cyc(3);
    chk(irq == 1'b1 && irq_vector == 8'h0B, "R2", "low level request", int'(irq_vector), 8'h0B);
    ack_once();
    chk(irq == 1'b1, "R7", "level request held through ack", int'(irq), 1);
    pins[1] = 1'b1;
    cyc(3);
    chk(irq == 1'b0, "R7", "level request dropped", int'(irq), 0);
    wr(3'd1, 4'h0);
    pins[1] = 1'b0;
    wr(3'd0, 4'hB);
    pins[0] = 1'b1;
    cyc(3);
    chk(irq == 1'b1 && irq_vector == 8'h03, "R2", "high level request", int'(irq_vector), 8'h03);
    pins[0] = 1'b0;
    cyc(3);
    chk(irq == 1'b0, "R2", "high level released", int'(irq), 0);
    wr(3'd0, 4'h0);
    cyc(5);

    // R3: both edges and falling edge on source 2
    mon_on <= 1'b1;
    cur_tag = "R3";
    wr(3'd2, 4'hA);
    push(8'h13, "R3");
    push(8'h13, "R3");
    pulse(2, 20);
    drain(20, "R3");
    wr(3'd2, 4'h9);
    push(8'h13, "R1");
    pulse(2, 1);
    drain(10, "R3");

    // R4: unsupported codes
    cur_tag = "R4";
    wr(3'd2, 4'h0);
    wr(3'd0, 4'hA);
    pulse(0, 3);
    pulse(0, 1);
    drain(10, "R4");
    wr(3'd0, 4'h0);
    wr(3'd2, 4'hB);
    @(negedge clk) pins[2] = 1'b1;
    cyc(10);
    chk(irq == 1'b0, "R4", "level code on edge-only source", int'(irq), 0);
    pins[2] = 1'b0;
    wr(3'd2, 4'h0);
    wr(3'd3, 4'hD);
    pulse(3, 10);
    drain(20, "R4");
    wr(3'd3, 4'h0);

    // R9: disabled source records nothing; config write clears pending
    cur_tag = "R9";
    wr(3'd1, 4'h0);
    pulse(1, 1);
    cyc(5);
    wr(3'd1, 4'h8);
    drain(10, "R9");
    mon_on <= 1'b0;
    pulse(1, 1);
    cyc(5);
    chk(irq == 1'b1, "R9", "pending before rewrite", int'(irq), 1);
    wr(3'd1, 4'h8);
    chk(irq == 1'b0, "R9", "pending after rewrite", int'(irq), 0);

    // R6: simultaneous requests on 0, 1 and 3
    wr(3'd0, 4'h8);
    wr(3'd3, 4'h8);
    @(negedge clk) pins = 4'b1011;
    cyc(4);
    pins = 4'h0;
    cyc(10);
    chk(irq == 1'b1 && irq_vector == 8'h03, "R6", "highest priority first", int'(irq_vector), 8'h03);
    push(8'h03, "R6");
    push(8'h0B, "R6");
    push(8'h1B, "R6");
    cur_tag = "R6";
    mon_on <= 1'b1;
    drain(30, "R6");
    wr(3'd0, 4'h0);
    wr(3'd1, 4'h0);

    // R8: filter on source 3 at each divisor
    cur_tag = "R8";
    pulse(3, 1);
    drain(20, "R8");
    push(8'h1B, "R8");
    pulse(3, 2);
    drain(20, "R8");
    wr(3'd4, 4'h1);
    pulse(3, 15);
    drain(60, "R8");
    push(8'h1B, "R8");
    pulse(3, 32);
    drain(60, "R8");
    wr(3'd4, 4'h2);
    cyc(150);
    pulse(3, 63);
    drain(200, "R8");
    push(8'h1B, "R8");
    pulse(3, 128);
    drain(300, "R8");
    mon_on <= 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule